// File: doc/BRIEF.md
# Subsystem Register Access Unit

This unit sits beside an execution core and carries out the two instructions that move data between core registers and registers held in attached subsystems. A 32-bit instruction word is decoded into a core register number, a subsystem number, a subsystem register index and an 8-bit command. The access is then either routed to one of sixteen subsystem ports over a valid/ready request with a separate response, or resolved inside the unit. A successful read returns data to the core's register file through a one-cycle write-back strobe. An access that cannot complete raises the unknown-instruction exception.

Subsystem 3 is the debug subsystem, and the unit holds its register 0 itself. This register reports whether the core runs in a simulator. Writing it in a simulator produces an end-of-simulation pulse. Writing it on real hardware is refused with the unknown-instruction exception. A parameter mask states which of the other subsystem numbers have a port. An access to any other number is refused and sends no request.

Top module: `ssa_unit`

## Requirements
- R1: The low 7 instruction bits hold the opcode. 0x7D is a subsystem read and 0x7E is a subsystem write. Any other opcode is ignored: no request, no write-back, no exception, no done pulse.
- R2: Instruction fields are core register [11:7], subsystem number [15:12], register index [23:16] and command [31:24]. While a request is raised, `ss_regidx_o` and `ss_cmd_o` carry the index and the command unchanged, and `ss_write_o` is 1 for a write and 0 for a read. For a write, `ss_wdata_o` carries `src_data_i` as sampled when the access was accepted.
- R3: An instruction is accepted in a cycle where `insn_valid_i` is high and `busy_o` is low. An external access raises only bit `ss_req_o[sid]` from the next cycle on. The bit stays high until the cycle in which `ss_ready_i[sid]` is high. `busy_o` stays high from that first request cycle until the response is taken.
- R4: While `busy_o` is high, incoming instructions are ignored. Only one access is outstanding at a time.
- R5: Take a response cycle in which `ss_rsp_valid_i[sid]` is high and `ss_rsp_err_i[sid]` is low, for a read. In the next cycle `wb_valid_o` pulses, with `wb_reg_o` equal to the core register field and `wb_data_o` equal to that port's `ss_rdata_i` slot. Responses and data on other ports are ignored.
- R6: Every finished access pulses `done_o` for one cycle, whether it succeeds or fails. A write never produces a write-back.
- R7: An error response pulses `exc_unknown_o` together with `done_o`, and no write-back happens.
- R8: A subsystem number other than 3 whose bit in `EXT_MASK` is 0 raises no request. It pulses `exc_unknown_o` and `done_o` in the cycle after acceptance.
- R9: A read of subsystem 3 register 0 raises no request. In the cycle after acceptance it writes back the value 1 when `sim_mode_i` is high and 0 otherwise.
- R10: A write to subsystem 3 register 0 with `sim_mode_i` high pulses `sim_end_o` in the cycle after acceptance, with no exception. With `sim_mode_i` low it pulses `exc_unknown_o` instead, and `sim_end_o` stays low.
- R11: Any access to subsystem 3 at a register index other than 0 pulses `exc_unknown_o` in the cycle after acceptance, with no request and no write-back.
- R12: After reset, `busy_o`, `ss_req_o`, `wb_valid_o`, `exc_unknown_o`, `sim_end_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| insn_valid_i | input | 1 | Instruction word present |
| insn_i | input | 32 | Instruction word |
| src_data_i | input | 32 | Core register value used as write data |
| sim_mode_i | input | 1 | High when the core runs in a simulator |
| busy_o | output | 1 | Access in flight, new instructions ignored |
| ss_req_o | output | 16 | Per-subsystem request valid |
| ss_ready_i | input | 16 | Per-subsystem request ready |
| ss_regidx_o | output | 8 | Subsystem register index |
| ss_cmd_o | output | 8 | Command passed through to the subsystem |
| ss_wdata_o | output | 32 | Write data |
| ss_write_o | output | 1 | 1 = write, 0 = read |
| ss_rsp_valid_i | input | 16 | Per-subsystem response valid |
| ss_rsp_err_i | input | 16 | Per-subsystem response error flag |
| ss_rdata_i | input | 512 | Per-subsystem read data, 32 bits per port, port k at [32k+31:32k] |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_reg_o | output | 5 | Core register to write |
| wb_data_o | output | 32 | Write-back data |
| exc_unknown_o | output | 1 | Unknown-instruction exception pulse |
| sim_end_o | output | 1 | End-of-simulation pulse |
| done_o | output | 1 | Access finished |

## Verification
Reads and writes go to several implemented ports with zero and non-zero ready and response delays. During the wait, responses on other ports are driven and every other data slot is filled with distinct values. This shows whether the response selection really follows the subsystem number. Error responses, unimplemented numbers and a foreign opcode show apart the refusal paths from the silent ignore. Debug register reads and writes with the simulation flag high and low, plus a debug access at a non-zero index, cover each branch of the internal register. An instruction offered while busy shows whether the single-outstanding rule holds.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
    localparam int XLEN     = 32;
    localparam int NUM_SS   = 16;
    localparam int SID_W    = $clog2(NUM_SS);
    localparam int IDX_W    = 8;
    localparam int CMD_W    = 8;
    localparam int RD_W     = 5;
    localparam int OP_W     = 7;

    localparam logic [OP_W-1:0]  OP_SS_READ  = 7'h7D;
    localparam logic [OP_W-1:0]  OP_SS_WRITE = 7'h7E;
    localparam logic [SID_W-1:0] DBG_SID     = 4'd3;
    localparam logic [IDX_W-1:0] DBG_SIMCTL  = 8'd0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ssa_state_e;

    typedef struct packed {
        logic [RD_W-1:0]  rd;
        logic [SID_W-1:0] sid;
        logic [IDX_W-1:0] idx;
        logic [CMD_W-1:0] cmd;
    } ssa_fields_t;

    typedef struct packed {
        ssa_state_e       state;
        logic [SID_W-1:0] sid;
        logic [RD_W-1:0]  rd;
        logic [IDX_W-1:0] idx;
        logic [CMD_W-1:0] cmd;
        logic [XLEN-1:0]  wdata;
        logic             write;
        logic             wb_valid;
        logic [XLEN-1:0]  wb_data;
        logic             exc;
        logic             sim_end;
        logic             done;
    } ssa_regs_t;
endpackage

// File: rtl/ssa_decode.sv
module ssa_decode
    import ssa_pkg::*;
(
    input  logic [XLEN-1:0] insn_i,
    output ssa_fields_t     fields_o,
    output logic            is_access_o,
    output logic            is_write_o
);
    localparam int RD_LO  = OP_W;
    localparam int SID_LO = RD_LO + RD_W;
    localparam int IDX_LO = SID_LO + SID_W;
    localparam int CMD_LO = IDX_LO + IDX_W;

    logic [OP_W-1:0] opcode;

    always_comb begin
        opcode       = insn_i[OP_W-1:0];
        fields_o.rd  = insn_i[RD_LO  +: RD_W];
        fields_o.sid = insn_i[SID_LO +: SID_W];
        fields_o.idx = insn_i[IDX_LO +: IDX_W];
        fields_o.cmd = insn_i[CMD_LO +: CMD_W];
        is_write_o   = (opcode == OP_SS_WRITE);
        is_access_o  = (opcode == OP_SS_READ) || (opcode == OP_SS_WRITE);
    end
endmodule

// File: rtl/ssa_dbgctl.sv
module ssa_dbgctl
    import ssa_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  logic             write_i,
    input  logic             sim_mode_i,
    output logic             ok_o,
    output logic [XLEN-1:0]  rdata_o,
    output logic             end_sim_o
);
    logic hit;

    always_comb begin
        hit       = (idx_i == DBG_SIMCTL);
        ok_o      = hit && (!write_i || sim_mode_i);
        rdata_o   = {{(XLEN-1){1'b0}}, sim_mode_i};
        end_sim_o = hit && write_i && sim_mode_i;
    end
endmodule

// File: rtl/ssa_rsp_pick.sv
module ssa_rsp_pick
    import ssa_pkg::*;
(
    input  logic [SID_W-1:0]       sid_i,
    input  logic [NUM_SS-1:0]      ready_i,
    input  logic [NUM_SS-1:0]      rsp_valid_i,
    input  logic [NUM_SS-1:0]      rsp_err_i,
    input  logic [NUM_SS*XLEN-1:0] rdata_i,
    output logic                   ready_o,
    output logic                   rsp_valid_o,
    output logic                   rsp_err_o,
    output logic [XLEN-1:0]        rdata_o
);
    logic [NUM_SS-1:0]    sel;
    logic [XLEN-1:0]      masked [NUM_SS];

    for (genvar g = 0; g < NUM_SS; g++) begin : g_port
        assign sel[g]    = (sid_i == SID_W'(g));
        assign masked[g] = sel[g] ? rdata_i[g*XLEN +: XLEN] : '0;
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_SS; k++) begin
            rdata_o = rdata_o | masked[k];
        end
        ready_o     = |(ready_i & sel);
        rsp_valid_o = |(rsp_valid_i & sel);
        rsp_err_o   = |(rsp_err_i & sel);
    end
endmodule

// File: rtl/ssa_unit.sv
module ssa_unit
    import ssa_pkg::*;
#(
    parameter logic [15:0] EXT_MASK = 16'h0017
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   insn_valid_i,
    input  logic [31:0]            insn_i,
    input  logic [31:0]            src_data_i,
    input  logic                   sim_mode_i,
    output logic                   busy_o,
    output logic [15:0]            ss_req_o,
    input  logic [15:0]            ss_ready_i,
    output logic [7:0]             ss_regidx_o,
    output logic [7:0]             ss_cmd_o,
    output logic [31:0]            ss_wdata_o,
    output logic                   ss_write_o,
    input  logic [15:0]            ss_rsp_valid_i,
    input  logic [15:0]            ss_rsp_err_i,
    input  logic [511:0]           ss_rdata_i,
    output logic                   wb_valid_o,
    output logic [4:0]             wb_reg_o,
    output logic [31:0]            wb_data_o,
    output logic                   exc_unknown_o,
    output logic                   sim_end_o,
    output logic                   done_o
);
    localparam logic [NUM_SS-1:0] PORT_MASK =
        EXT_MASK & ~(NUM_SS'(1) << DBG_SID);

    ssa_regs_t   q, d;
    ssa_fields_t f;
    logic        dec_access, dec_write;
    logic        dbg_ok, dbg_end;
    logic [XLEN-1:0] dbg_rdata;
    logic        sel_ready, sel_valid, sel_err;
    logic [XLEN-1:0] sel_rdata;

    ssa_decode u_dec (
        .insn_i      (insn_i),
        .fields_o    (f),
        .is_access_o (dec_access),
        .is_write_o  (dec_write)
    );

    ssa_dbgctl u_dbg (
        .idx_i      (f.idx),
        .write_i    (dec_write),
        .sim_mode_i (sim_mode_i),
        .ok_o       (dbg_ok),
        .rdata_o    (dbg_rdata),
        .end_sim_o  (dbg_end)
    );

    ssa_rsp_pick u_pick (
        .sid_i       (q.sid),
        .ready_i     (ss_ready_i),
        .rsp_valid_i (ss_rsp_valid_i),
        .rsp_err_i   (ss_rsp_err_i),
        .rdata_i     (ss_rdata_i),
        .ready_o     (sel_ready),
        .rsp_valid_o (sel_valid),
        .rsp_err_o   (sel_err),
        .rdata_o     (sel_rdata)
    );

    always_comb begin
        d          = q;
        d.wb_valid = 1'b0;
        d.exc      = 1'b0;
        d.sim_end  = 1'b0;
        d.done     = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (insn_valid_i && dec_access) begin
                    d.sid   = f.sid;
                    d.rd    = f.rd;
                    d.idx   = f.idx;
                    d.cmd   = f.cmd;
                    d.write = dec_write;
                    d.wdata = dec_write ? src_data_i : '0;
                    if (f.sid == DBG_SID) begin
                        d.done = 1'b1;
                        if (!dbg_ok) begin
                            d.exc = 1'b1;
                        end else if (dec_write) begin
                            d.sim_end = dbg_end;
                        end else begin
                            d.wb_valid = 1'b1;
                            d.wb_data  = dbg_rdata;
                        end
                    end else if (!PORT_MASK[f.sid]) begin
                        d.done = 1'b1;
                        d.exc  = 1'b1;
                    end else begin
                        d.state = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (sel_ready) begin
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (sel_valid) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    if (sel_err) begin
                        d.exc = 1'b1;
                    end else if (!q.write) begin
                        d.wb_valid = 1'b1;
                        d.wb_data  = sel_rdata;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NUM_SS; g++) begin : g_req
        if (PORT_MASK[g]) begin : g_on
            assign ss_req_o[g] = (q.state == ST_REQ) && (q.sid == SID_W'(g));
        end else begin : g_off
            assign ss_req_o[g] = 1'b0;
        end
    end

    assign busy_o        = (q.state != ST_IDLE);
    assign ss_regidx_o   = q.idx;
    assign ss_cmd_o      = q.cmd;
    assign ss_wdata_o    = q.wdata;
    assign ss_write_o    = q.write;
    assign wb_valid_o    = q.wb_valid;
    assign wb_reg_o      = q.rd;
    assign wb_data_o     = q.wb_data;
    assign exc_unknown_o = q.exc;
    assign sim_end_o     = q.sim_end;
    assign done_o        = q.done;

    // R3: at most one port requested at a time
    p_req_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ss_req_o));

    // R3: a request not yet taken stays on with the same payload
    p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ss_req_o & ss_ready_i) == '0 && ss_req_o != '0) |=>
            ($stable(ss_req_o) && $stable(ss_regidx_o) && $stable(ss_cmd_o)));

    // R4: no completion while an access is still in flight
    p_busy_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !done_o);

    // R7: an exception never comes with a write-back
    p_exc_no_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_unknown_o |-> !wb_valid_o);

    // R6: write-back only as part of a finished access
    p_wb_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_valid_o |-> done_o);

    // R8: no request to a number without a port
    p_req_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ss_req_o & ~PORT_MASK) == '0);

    // R10: end of simulation only follows a cycle with the flag high
    p_end_sim_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sim_end_o |-> ($past(sim_mode_i) && !exc_unknown_o));
endmodule

// File: tb/test_ssa_unit.sv
module test_ssa_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         insn_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [31:0]  src = '0;
    logic         sim = 1'b0;
    logic         busy;
    logic [15:0]  ss_req;
    logic [15:0]  ss_ready = '0;
    logic [7:0]   ss_idx;
    logic [7:0]   ss_cmd;
    logic [31:0]  ss_wdata;
    logic         ss_write;
    logic [15:0]  rsp_valid = '0;
    logic [15:0]  rsp_err = '0;
    logic [511:0] rdata = '0;
    logic         wb_valid;
    logic [4:0]   wb_reg;
    logic [31:0]  wb_data;
    logic         exc;
    logic         sim_end;
    logic         done;

    localparam logic [15:0] PORTS = 16'h0017;

    always #2.5 clk = ~clk;

    ssa_unit i_ssa_unit (
        .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(insn_valid), .insn_i(insn),
        .src_data_i(src), .sim_mode_i(sim), .busy_o(busy), .ss_req_o(ss_req),
        .ss_ready_i(ss_ready), .ss_regidx_o(ss_idx), .ss_cmd_o(ss_cmd),
        .ss_wdata_o(ss_wdata), .ss_write_o(ss_write), .ss_rsp_valid_i(rsp_valid),
        .ss_rsp_err_i(rsp_err), .ss_rdata_i(rdata), .wb_valid_o(wb_valid),
        .wb_reg_o(wb_reg), .wb_data_o(wb_data), .exc_unknown_o(exc),
        .sim_end_o(sim_end), .done_o(done)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R12";
    bit    finished = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference model: 0 idle, 1 request, 2 waiting
    int          m_st = 0;
    int          m_sid = 0;
    int          m_rd = 0, m_idx = 0, m_cmd = 0;
    bit          m_wr = 0;
    logic [31:0] m_wd = '0;
    bit          m_wb = 0, m_exc = 0, m_end = 0, m_done = 0;
    logic [31:0] m_wbd = '0;
    int          r_sid;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_wb = 0; m_exc = 0; m_end = 0; m_done = 0;
        end else begin
            m_wb = 0; m_exc = 0; m_end = 0; m_done = 0;
            if (m_st == 0) begin
                if (insn_valid && (insn[6:0] == 7'h7D || insn[6:0] == 7'h7E)) begin
                    m_wr  = (insn[6:0] == 7'h7E);
                    m_rd  = int'(insn[11:7]);
                    r_sid = int'(insn[15:12]);
                    m_idx = int'(insn[23:16]);
                    m_cmd = int'(insn[31:24]);
                    m_wd  = src;
                    m_sid = r_sid;
                    if (r_sid == 3) begin
                        m_done = 1;
                        if (m_idx != 0) m_exc = 1;
                        else if (m_wr) begin
                            if (sim) m_end = 1; else m_exc = 1;
                        end else begin
                            m_wb = 1; m_wbd = sim ? 32'd1 : 32'd0;
                        end
                    end else if (!PORTS[r_sid]) begin
                        m_done = 1; m_exc = 1;
                    end else m_st = 1;
                end
            end else if (m_st == 1) begin
                if (ss_ready[m_sid]) m_st = 2;
            end else begin
                if (rsp_valid[m_sid]) begin
                    m_st = 0; m_done = 1;
                    if (rsp_err[m_sid]) m_exc = 1;
                    else if (!m_wr) begin
                        m_wb = 1; m_wbd = rdata[m_sid*32 +: 32];
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("busy", 32'(busy), 32'(m_st != 0));
            chk("ss_req", 32'(ss_req), (m_st == 1) ? (32'd1 << m_sid) : 32'd0);
            if (m_st == 1) begin
                chk("ss_regidx", 32'(ss_idx), 32'(m_idx));
                chk("ss_cmd", 32'(ss_cmd), 32'(m_cmd));
                chk("ss_write", 32'(ss_write), 32'(m_wr));
                if (m_wr) chk("ss_wdata", ss_wdata, m_wd);
            end
            chk("wb_valid", 32'(wb_valid), 32'(m_wb));
            if (m_wb) begin
                chk("wb_reg", 32'(wb_reg), 32'(m_rd));
                chk("wb_data", wb_data, m_wbd);
            end
            chk("exc_unknown", 32'(exc), 32'(m_exc));
            chk("sim_end", 32'(sim_end), 32'(m_end));
            chk("done", 32'(done), 32'(m_done));
        end
    end

    task automatic access(input logic [6:0] op, input logic [4:0] rd, input logic [3:0] sid,
                          input logic [7:0] idx, input logic [7:0] cmd, input logic [31:0] wd,
                          input logic s, input int rdy_dly, input int rsp_dly,
                          input logic err, input logic [31:0] rv, input bit ext);
        @(negedge clk);
        insn_valid = 1'b1; insn = {cmd, idx, sid, rd, op}; src = wd; sim = s;
        @(negedge clk);
        insn_valid = 1'b0; src = 32'hDEAD_0000;
        if (ext) begin
            repeat (rdy_dly) @(negedge clk);
            ss_ready = 16'd1 << sid;
            @(negedge clk);
            ss_ready = '0;
            for (int k = 0; k < 16; k++) rdata[k*32 +: 32] = 32'hA500_0000 | 32'(k * 17);
            for (int w = 0; w < rsp_dly; w++) begin
                rsp_valid = ~(16'd1 << sid);
                rsp_err   = 16'hFFFF;
                @(negedge clk);
            end
            rsp_valid = 16'd1 << sid;
            rsp_err   = err ? (16'd1 << sid) : 16'd0;
            rdata[sid*32 +: 32] = rv;
            @(negedge clk);
            rsp_valid = '0; rsp_err = '0;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs quiet under and right after reset
        chk("busy", 32'(busy), 0);
        chk("ss_req", 32'(ss_req), 0);
        chk("wb_valid", 32'(wb_valid), 0);
        chk("exc", 32'(exc), 0);
        chk("sim_end", 32'(sim_end), 0);
        chk("done", 32'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        tag = "R5"; access(7'h7D, 5'd9, 4'd1, 8'h20, 8'h01, 32'h0, 1'b0, 0, 0, 1'b0, 32'h1234_5678, 1);
        tag = "R5"; access(7'h7D, 5'd31, 4'd4, 8'hFF, 8'hC3, 32'h0, 1'b0, 3, 4, 1'b0, 32'hCAFE_F00D, 1);
        tag = "R2"; access(7'h7E, 5'd2, 4'd0, 8'h5A, 8'h80, 32'h0BAD_BEEF, 1'b0, 2, 1, 1'b0, 32'h1111_1111, 1);
        tag = "R6"; access(7'h7E, 5'd7, 4'd2, 8'h01, 8'h00, 32'h7777_0001, 1'b0, 0, 2, 1'b0, 32'h2222_2222, 1);
        tag = "R7"; access(7'h7D, 5'd3, 4'd2, 8'h10, 8'h04, 32'h0, 1'b0, 1, 0, 1'b1, 32'h3333_3333, 1);
        tag = "R7"; access(7'h7E, 5'd3, 4'd1, 8'h10, 8'h04, 32'h5, 1'b0, 0, 3, 1'b1, 32'h3333_3333, 1);
        tag = "R8"; access(7'h7D, 5'd4, 4'd5, 8'h00, 8'h00, 32'h0, 1'b0, 0, 0, 1'b0, 32'h0, 0);
        tag = "R8"; access(7'h7E, 5'd4, 4'd15, 8'h09, 8'h02, 32'h9, 1'b0, 0, 0, 1'b0, 32'h0, 0);
        tag = "R9"; access(7'h7D, 5'd6, 4'd3, 8'h00, 8'h00, 32'h0, 1'b1, 0, 0, 1'b0, 32'h0, 0);
        tag = "R9"; access(7'h7D, 5'd6, 4'd3, 8'h00, 8'h00, 32'h0, 1'b0, 0, 0, 1'b0, 32'h0, 0);
        tag = "R10"; access(7'h7E, 5'd0, 4'd3, 8'h00, 8'h00, 32'h1, 1'b1, 0, 0, 1'b0, 32'h0, 0);
        tag = "R10"; access(7'h7E, 5'd0, 4'd3, 8'h00, 8'h00, 32'h1, 1'b0, 0, 0, 1'b0, 32'h0, 0);
        tag = "R11"; access(7'h7D, 5'd1, 4'd3, 8'h01, 8'h00, 32'h0, 1'b1, 0, 0, 1'b0, 32'h0, 0);
        tag = "R11"; access(7'h7E, 5'd1, 4'd3, 8'h20, 8'h00, 32'h0, 1'b1, 0, 0, 1'b0, 32'h0, 0);
        tag = "R1"; access(7'h7F, 5'd1, 4'd1, 8'h00, 8'h00, 32'h0, 1'b0, 0, 0, 1'b0, 32'h0, 0);
        tag = "R1"; access(7'h7C, 5'd1, 4'd3, 8'h00, 8'h00, 32'h0, 1'b1, 0, 0, 1'b0, 32'h0, 0);

        // R4: instruction offered while busy is dropped
        tag = "R4";
        @(negedge clk);
        insn_valid = 1'b1; insn = {8'h00, 8'h02, 4'd1, 5'd8, 7'h7D};
        @(negedge clk);
        insn = {8'h00, 8'h00, 4'd3, 5'd9, 7'h7D};
        @(negedge clk);
        insn_valid = 1'b0;
        chk("busy_held", 32'(busy), 1);
        ss_ready = 16'h0002;
        @(negedge clk);
        ss_ready = '0;
        rsp_valid = 16'h0002; rdata[32 +: 32] = 32'h4444_0004;
        @(negedge clk);
        rsp_valid = '0;
        chk("wb_reg_first", 32'(wb_reg), 32'd8);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule